// File: doc/BRIEF.md
# Programmable Countdown Timer with Selectable Timebase

This block is a countdown timer of the kind found beside a local interrupt controller. Software programs it through a small register port with write and read strobes, an address and data. Writing a start value begins a countdown. When the count reaches zero, the block can raise a one-cycle interrupt request that carries an 8-bit vector. The count then either stops or reloads from the start value and runs again.

The block decrements on a count tick, and the tick source is chosen at run time. It can be every main clock cycle, each rising edge of an external timebase pin, or the output of a power-of-two prescaler. The prescaler itself takes its input from either the main clock or the external pin. Selecting the prescaler output gives the same behaviour as a timer that always counts a divided clock. The external pin is asynchronous: it is synchronised, and each rising edge becomes one single-cycle tick.

Register offsets: 0 holds the control/vector word, 1 the prescaler setup, 2 the start value and 3 the live count. The read data is combinational while the read strobe is high and zero otherwise.

Top module: `tick_timer`

## Requirements
- R1: With source field (control bits 19:18) = 00, the count falls by one every main clock cycle. After a start value N is written, the interrupt appears exactly N cycles after the write edge.
- R2: With source field = 01, the count falls once per rising edge of `ext_tb`. The decrement lands three clock edges after the edge is presented. Without edges, the count holds.
- R3: With source field = 10, the count follows the prescaler. Prescaler bits 1:0 select the ratio: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16. The prescaler phase restarts when a start value is written.
- R4: Prescaler bit 2 selects the prescaler input: 0 takes the main clock and 1 takes the synchronised `ext_tb` edges.
- R5: Prescaler bit 3 always reads 0, and writing it has no effect. Bits 2:0 read back as written.
- R6: Source field value 11 behaves exactly as 10.
- R7: Writing the start value (offset 2) loads the live count and starts the countdown. A start value of 0 stops the timer and leaves the count at 0.
- R8: Control bit 17 = 1 selects periodic mode, which reloads the start value on reaching zero. Bit 17 = 0 selects one-shot mode, which stops at 0 with no further interrupts.
- R9: On reaching zero with control bit 16 (mask) = 0, `irq` is high for one cycle and `irq_vec` equals control bits 7:0. With the mask set, no interrupt is raised.
- R10: Offset 3 returns the live count, and writes to it have no effect on the countdown.
- R11: After reset, the control word reads 0x00010000 (masked, source 00, one-shot, vector 0). The prescaler setup, start value and live count read 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register offset |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, zero when rd_en is low |
| ext_tb | input | 1 | Asynchronous external timebase |
| irq | output | 1 | One-cycle timer interrupt request |
| irq_vec | output | 8 | Vector carried with the request |

## Verification
A wrong count, prescaler phase or source choice moves the interrupt away from its computed cycle. The scoreboard compares the cycle of every request against a prediction, so the error shows at the first expiry, at most a few dozen cycles after the write. A stray reload or a missed stop appears as an interrupt with no matching entry within one period. A corrupted register field shows on the next read, and a faulty vector shows on the next request. Live-count reads taken mid-countdown expose a bad decrement before expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      SRC_CLK = 2'b00,
      SRC_EXT = 2'b01,
      SRC_DIV = 2'b10,
      SRC_RSV = 2'b11
   } tsrc_e;

   localparam int VEC_LSB  = 0;
   localparam int MASK_BIT = 16;
   localparam int PER_BIT  = 17;
   localparam int SRC_LSB  = 18;
   localparam int CTRL_MSB = 19;

   localparam int OFF_CTRL = 0;
   localparam int OFF_PRE  = 1;
   localparam int OFF_INIT = 2;
   localparam int OFF_CUR  = 3;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sr_q   <= {sr_q[STAGES-2:0], async_in};
         last_q <= sr_q[STAGES-1];
      end
   end

   assign rise = sr_q[STAGES-1] & ~last_q;

   // R2
   ext_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PW = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       sel_ext,
   input  logic       ext_tick,
   input  logic [1:0] ratio,
   output logic       div_tick
);
   if (PW < 4) begin : g_bad_pw
      $error("tmr_prescale: PW must hold a count of 15");
   end

   logic          in_tick;
   logic [PW-1:0] lim;
   logic [PW-1:0] pcnt_q;

   assign in_tick = sel_ext ? ext_tick : 1'b1;

   always_comb begin
      case (ratio)
         2'b00:   lim = PW'(1);
         2'b01:   lim = PW'(3);
         2'b10:   lim = PW'(7);
         default: lim = PW'(15);
      endcase
   end

   assign div_tick = in_tick && (pcnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt_q <= '0;
      else if (clr)              pcnt_q <= '0;
      else if (in_tick) begin
         if (pcnt_q >= lim)      pcnt_q <= '0;
         else                    pcnt_q <= pcnt_q + PW'(1);
      end
   end

   // R3
   div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_tick && !clr) |=> (pcnt_q == '0));
   // R4
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_tick && !clr) |=> $stable(pcnt_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   input  logic          periodic,
   input  logic          mask,
   input  logic [7:0]    vec,
   output logic [CW-1:0] cur,
   output logic [CW-1:0] init,
   output logic          irq,
   output logic [7:0]    irq_vec
);
   logic [CW-1:0] init_q, cur_q;
   logic          run_q, irq_q, fire;
   logic [7:0]    ivec_q;

   assign fire = run_q && tick && !load && (cur_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         cur_q  <= '0;
         run_q  <= 1'b0;
      end else if (load) begin
         init_q <= load_val;
         cur_q  <= load_val;
         run_q  <= |load_val;
      end else if (run_q && tick) begin
         if (cur_q == CW'(1)) begin
            if (periodic) cur_q <= init_q;
            else begin
               cur_q <= '0;
               run_q <= 1'b0;
            end
         end else begin
            cur_q <= cur_q - CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         ivec_q <= '0;
      end else begin
         irq_q <= fire && !mask;
         if (fire && !mask) ivec_q <= vec;
      end
   end

   assign cur     = cur_q;
   assign init    = init_q;
   assign irq     = irq_q;
   assign irq_vec = ivec_q;

   // R1
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick && !load && cur_q > CW'(1)) |=> (cur_q == $past(cur_q) - CW'(1)));
   // R7
   zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == '0 && !load) |=> (cur_q == '0));
   // R8
   oneshot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !periodic) |=> (cur_q == '0 && !run_q));
   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && periodic) |=> (cur_q == $past(init_q)));
   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mask) |=> !irq_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int AW          = 4,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2,
   parameter int PW          = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          ext_tb,
   output logic          irq,
   output logic [7:0]    irq_vec
);
   import tmr_pkg::*;

   if (DW < CTRL_MSB + 1) begin : g_bad_dw
      $error("tick_timer: DW too narrow for the control word");
   end
   if (AW < 2) begin : g_bad_aw
      $error("tick_timer: AW must cover four offsets");
   end

   localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
   localparam logic [AW-1:0] A_PRE  = AW'(OFF_PRE);
   localparam logic [AW-1:0] A_INIT = AW'(OFF_INIT);
   localparam logic [AW-1:0] A_CUR  = AW'(OFF_CUR);

   logic [7:0]    vec_q;
   logic          mask_q, per_q;
   tsrc_e         src_q;
   logic [2:0]    pre_q;
   logic          load, ext_tick, div_tick, tick;
   logic [DW-1:0] cur, init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= 1'b1;
         per_q  <= 1'b0;
         src_q  <= SRC_CLK;
         pre_q  <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) begin
            vec_q  <= wdata[VEC_LSB +: 8];
            mask_q <= wdata[MASK_BIT];
            per_q  <= wdata[PER_BIT];
            src_q  <= tsrc_e'(wdata[SRC_LSB +: 2]);
         end
         if (addr == A_PRE) pre_q <= wdata[2:0];
      end
   end

   assign load = wr_en && (addr == A_INIT);

   tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_tb), .rise(ext_tick));

   tmr_prescale #(.PW(PW)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(load), .sel_ext(pre_q[2]),
      .ext_tick(ext_tick), .ratio(pre_q[1:0]), .div_tick(div_tick));

   always_comb begin
      case (src_q)
         SRC_CLK: tick = 1'b1;
         SRC_EXT: tick = ext_tick;
         default: tick = div_tick;
      endcase
   end

   tmr_count #(.CW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(wdata), .tick(tick),
      .periodic(per_q), .mask(mask_q), .vec(vec_q), .cur(cur), .init(init),
      .irq(irq), .irq_vec(irq_vec));

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == A_CTRL) begin
            rdata[VEC_LSB +: 8] = vec_q;
            rdata[MASK_BIT]     = mask_q;
            rdata[PER_BIT]      = per_q;
            rdata[SRC_LSB +: 2] = src_q;
         end else if (addr == A_PRE) begin
            rdata[2:0] = pre_q;
         end else if (addr == A_INIT) begin
            rdata = init;
         end else if (addr == A_CUR) begin
            rdata = cur;
         end
      end
   end

   // R5
   pre_bit3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_PRE) |-> (rdata[3] == 1'b0));
   // R10
   cur_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CUR && !tick) |=> $stable(cur));
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, ext_tb = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [7:0]  irq_vec;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   typedef struct { int at; logic [7:0] v; } exp_t;
   exp_t sb[$];

   tick_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .ext_tb(ext_tb),
      .irq(irq), .irq_vec(irq_vec));

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // monitor: pops expected interrupts and compares cycle and vector
   always @(negedge clk) begin
      if (rst_n && irq) begin
         if (sb.size() == 0) check("R8/R9 unexpected irq", 32'(cyc), 32'hFFFF_FFFF);
         else begin
            exp_t e;
            e = sb.pop_front();
            check("R1/R9 irq cycle", 32'(cyc), 32'(e.at));
            check("R9 irq vector", 32'(irq_vec), 32'(e.v));
         end
      end
   end

   task automatic push(input int at, input logic [7:0] v);
      exp_t e;
      e.at = at; e.v = v;
      sb.push_back(e);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, output int w);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; w = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v, output int c);
      @(negedge clk);
      rd_en = 1'b1; addr = a; c = cyc;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drained(input string req);
      check(req, 32'(sb.size()), 32'd0);
   endtask

   // n rising edges on ext_tb; returns cycle of the last edge
   task automatic pulses(input int n, output int last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ext_tb = 1'b1; last = cyc;
         idle(2);
         ext_tb = 1'b0;
         idle(2);
      end
   endtask

   initial begin
      int w, c, last;
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      // R11 reset state
      check("R11 irq", 32'(irq), 32'd0);
      rd(4'd0, v, c); check("R11 ctrl", v, 32'h0001_0000);
      rd(4'd1, v, c); check("R11 pre", v, 32'd0);
      rd(4'd2, v, c); check("R11 init", v, 32'd0);
      rd(4'd3, v, c); check("R11 cur", v, 32'd0);

      // R1 main clock, one-shot; R10 live read and ignored write
      wr(4'd0, 32'h0000_003C, w);
      wr(4'd2, 32'd5, w); push(w + 1 + 5, 8'h3C);
      rd(4'd3, v, c); check("R10 live count", v, 32'(5 - (c - (w + 1))));
      wr(4'd3, 32'd100, c);
      rd(4'd3, v, c); check("R10 write ignored", v, 32'(5 - (c - (w + 1))));
      idle(20); drained("R1 one-shot");
      rd(4'd3, v, c); check("R8 one-shot stays 0", v, 32'd0);

      // R8 periodic
      wr(4'd0, 32'h0002_0041, w);
      wr(4'd2, 32'd4, w);
      push(w + 5, 8'h41); push(w + 9, 8'h41); push(w + 13, 8'h41);
      idle(12);
      wr(4'd2, 32'd0, c);
      idle(20); drained("R8 periodic");

      // R7 zero start value stops
      wr(4'd0, 32'h0000_0011, w);
      wr(4'd2, 32'd6, w);
      wr(4'd2, 32'd0, w);
      idle(20); drained("R7 stop");
      rd(4'd3, v, c); check("R7 cur zero", v, 32'd0);

      // R9 mask
      wr(4'd0, 32'h0001_0022, w);
      wr(4'd2, 32'd3, w);
      idle(10); drained("R9 masked");
      rd(4'd3, v, c); check("R9 masked count ran", v, 32'd0);

      // R3 prescaler ratios
      for (int r = 0; r < 4; r++) begin
         wr(4'd1, 32'(r), w);
         wr(4'd0, 32'h0008_0050 + 32'(r), w);
         wr(4'd2, 32'd3, w); push(w + 1 + 3 * (2 << r), 8'h50 + 8'(r));
         idle(3 * (2 << r) + 5); drained("R3 ratio");
      end

      // R6 reserved source behaves as divider
      wr(4'd1, 32'd1, w);
      wr(4'd0, 32'h000C_0060, w);
      wr(4'd2, 32'd2, w); push(w + 1 + 8, 8'h60);
      idle(15); drained("R6 reserved");

      // R5 prescaler bit 3
      wr(4'd1, 32'hF, w);
      rd(4'd1, v, c); check("R5 bit3 reads 0", v, 32'h7);
      wr(4'd1, 32'h8, w);
      rd(4'd1, v, c); check("R5 bit3 alone", v, 32'h0);

      // R2 external timebase
      wr(4'd0, 32'h0004_0070, w);
      wr(4'd2, 32'd3, w);
      idle(10);
      rd(4'd3, v, c); check("R2 holds without edges", v, 32'd3);
      pulses(2, last);
      rd(4'd3, v, c); check("R2 two edges", v, 32'd1);
      @(negedge clk); ext_tb = 1'b1; push(cyc + 3, 8'h70);
      idle(2); ext_tb = 1'b0;
      idle(10); drained("R2 ext");

      // R4 prescaler fed by ext edges, ratio 2
      wr(4'd1, 32'h4, w);
      wr(4'd0, 32'h0008_0071, w);
      wr(4'd2, 32'd2, w);
      idle(10);
      rd(4'd3, v, c); check("R4 main clock not used", v, 32'd2);
      pulses(3, last);
      @(negedge clk); ext_tb = 1'b1; push(cyc + 3, 8'h71);
      idle(2); ext_tb = 1'b0;
      idle(10); drained("R4 ext divider");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule